// File: doc/BRIEF.md
# Noise Shift-Register Generator

This block supplies the single pseudo-random noise bit that every voice of a programmable sound generator mixes in. A 17-bit shift register moves one place toward bit 0 each time it steps, and the bit it shifts in at the top is the exclusive-OR of two low taps. How often it steps is set by a period value: an internal counter counts `tick_en` pulses, which arrive from an external divider at half the tone step rate, and the register steps once per period's worth of pulses.

Two tap modes exist. In the standard mode the period takes only its five low bits and the taps are bits 0 and 3. In the alternate mode the period is eight bits wide and the taps are bits 0 and 2. A period of zero counts as one. The period and the mode are plain control pins, so they can change at any cycle. A change never reloads the shift register. It only alters the next period comparison and the next feedback. The noise bit is a plain level with no flow control, because every consumer samples it continuously.

Top module: `psg_noise_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, the shift register holds the seed value 1, so `noise_bit` reads 1 and the period count is zero.
- R2: In standard mode (`alt_mode` = 0) a step moves every register bit down one place (bit k takes bit k+1) and loads bit 16 with bit 0 XOR bit 3 of the old value.
- R3: In alternate mode (`alt_mode` = 1) a step loads bit 16 with bit 0 XOR bit 2 of the old value, with the same downward shift.
- R4: `noise_bit` equals bit 0 of the shift register and updates on the clock edge at which the register steps.
- R5: In standard mode only `period_in[4:0]` sets the period, and bits 7..5 have no effect on the stepping.
- R6: In alternate mode all eight bits of `period_in` set the period, from 1 to 255.
- R7: A period of 0 steps exactly like a period of 1, so the register steps on every `tick_en`.
- R8: The register steps once on every Nth `tick_en` pulse, where N is the effective period. Cycles without `tick_en` change neither the count nor the register.
- R9: A new period or mode takes effect at the next `tick_en` comparison without reseeding. If the count already reaches the new period, the next `tick_en` steps the register and clears the count.
- R10: The shift register never holds all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle rate pulse from the prescaler |
| alt_mode | input | 1 | 0 = standard taps and 5-bit period, 1 = alternate taps and 8-bit period |
| period_in | input | 8 | Noise period value |
| noise_bit | output | 1 | Current noise bit (bit 0 of the shift register) |

## Verification
The bench builds the block with its default parameters: a 17-bit register, a 5-bit standard period, an 8-bit alternate period, and the alternate mode present. Small random periods produce many count wraps in a short run. Occasional directed periods near 255 check that the full alternate width works. Random switching between modes and periods while the count is high reaches the case in R9 where the count already passes a newly lowered period. A long random run also walks the register far enough through its sequence to catch a wrong tap or a wrong shift direction.

// File: rtl/psg_noise_pkg.sv
package psg_noise_pkg;
  localparam int NZ_LFSR_W    = 17;
  localparam int NZ_STD_PER_W = 5;
  localparam int NZ_ALT_PER_W = 8;
  localparam int NZ_STD_TAP   = 3;
  localparam int NZ_ALT_TAP   = 2;
  localparam logic [NZ_LFSR_W-1:0] NZ_SEED = NZ_LFSR_W'(1);

  typedef enum logic {
    TAP_STD = 1'b0,
    TAP_ALT = 1'b1
  } tap_mode_e;
endpackage

// File: rtl/noise_period_sel.sv
module noise_period_sel
  import psg_noise_pkg::*;
#(
  parameter int STD_PER_W = NZ_STD_PER_W,
  parameter int ALT_PER_W = NZ_ALT_PER_W,
  parameter bit HAS_ALT   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tap_mode_e            mode,
  input  logic [ALT_PER_W-1:0] period_in,
  output logic [ALT_PER_W-1:0] per_eff
);
  localparam int PAD_W = ALT_PER_W - STD_PER_W;

  logic [ALT_PER_W-1:0] raw;
  logic [ALT_PER_W-1:0] std_view;

  assign std_view = {{PAD_W{1'b0}}, period_in[STD_PER_W-1:0]};

  generate
    if (HAS_ALT) begin : g_alt
      assign raw = (mode == TAP_ALT) ? period_in : std_view;
    end else begin : g_std_only
      assign raw = std_view;
    end
  endgenerate

  always_comb begin
    per_eff = raw;
    if (raw == '0) per_eff = ALT_PER_W'(1);
  end

  // R7
  period_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_eff != '0);

  // R5
  std_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TAP_STD) |-> (per_eff < ALT_PER_W'(1 << STD_PER_W)));
endmodule

// File: rtl/noise_rate_counter.sv
module noise_rate_counter
  import psg_noise_pkg::*;
#(
  parameter int CNT_W = NZ_ALT_PER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] per_eff,
  output logic             step
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_inc;
  logic             reached;

  assign cnt_inc = {1'b0, cnt} + (CNT_W+1)'(1);
  assign reached = cnt_inc >= {1'b0, per_eff};
  assign step    = tick_en && reached;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick_en) begin
      if (reached) cnt <= '0;
      else         cnt <= cnt_inc[CNT_W-1:0];
    end
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));

  // R9
  wrap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt == '0));

  // R8
  step_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> tick_en);
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
  import psg_noise_pkg::*;
#(
  parameter int LFSR_W  = NZ_LFSR_W,
  parameter int STD_TAP = NZ_STD_TAP,
  parameter int ALT_TAP = NZ_ALT_TAP,
  parameter logic [LFSR_W-1:0] SEED = NZ_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  tap_mode_e         mode,
  output logic [LFSR_W-1:0] state
);
  logic fb;
  logic tap_bit;

  assign tap_bit = (mode == TAP_ALT) ? state[ALT_TAP] : state[STD_TAP];
  assign fb      = state[0] ^ tap_bit;

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= SEED;
    else if (advance) state <= {fb, state[LFSR_W-1:1]};
  end

  // R10
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  // R8
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(state));

  // R2
  lfsr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (state[LFSR_W-2:0] == $past(state[LFSR_W-1:1])));
endmodule

// File: rtl/psg_noise_gen.sv
module psg_noise_gen
  import psg_noise_pkg::*;
#(
  parameter int LFSR_W    = NZ_LFSR_W,
  parameter int STD_PER_W = NZ_STD_PER_W,
  parameter int ALT_PER_W = NZ_ALT_PER_W,
  parameter int STD_TAP   = NZ_STD_TAP,
  parameter int ALT_TAP   = NZ_ALT_TAP,
  parameter bit HAS_ALT   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 alt_mode,
  input  logic [ALT_PER_W-1:0] period_in,
  output logic                 noise_bit
);
  localparam logic [LFSR_W-1:0] SEED_V = LFSR_W'(1);

  tap_mode_e            mode;
  logic [ALT_PER_W-1:0] per_eff;
  logic                 step;
  logic [LFSR_W-1:0]    state;

  assign mode = (HAS_ALT && alt_mode) ? TAP_ALT : TAP_STD;

  noise_period_sel #(
    .STD_PER_W(STD_PER_W),
    .ALT_PER_W(ALT_PER_W),
    .HAS_ALT  (HAS_ALT)
  ) u_per (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .period_in(period_in),
    .per_eff  (per_eff)
  );

  noise_rate_counter #(
    .CNT_W(ALT_PER_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_en(tick_en),
    .per_eff(per_eff),
    .step   (step)
  );

  noise_lfsr #(
    .LFSR_W (LFSR_W),
    .STD_TAP(STD_TAP),
    .ALT_TAP(ALT_TAP),
    .SEED   (SEED_V)
  ) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(step),
    .mode   (mode),
    .state  (state)
  );

  assign noise_bit = state[0];

  // R1
  reset_seed_chk: assert property (@(posedge clk)
    !rst_n |=> (noise_bit == 1'b1));
endmodule

// File: tb/tb_psg_noise_gen.sv
`timescale 1ns/1ps
module tb_psg_noise_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       alt_mode = 1'b0;
  logic [7:0] period_in = 8'd0;
  logic       noise_bit;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [16:0] m_lfsr;
  int          m_cnt;

  always #10 clk = ~clk;

  psg_noise_gen dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .alt_mode(alt_mode), .period_in(period_in), .noise_bit(noise_bit)
  );

  function automatic int eff_period(logic [7:0] p, logic alt);
    int v;
    v = alt ? int'(p) : int'(p[4:0]);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [16:0] next_state(logic [16:0] s, logic alt);
    logic fb;
    fb = s[0] ^ (alt ? s[2] : s[3]);
    return {fb, s[16:1]};
  endfunction

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: noise_bit=%0b expected %0b", tag, act, exp);
    end
  endtask

  // Model update for the coming rising edge, using the inputs now driven.
  task automatic model_edge();
    if (!rst_n) begin
      m_lfsr = 17'd1;
      m_cnt  = 0;
    end else if (tick_en) begin
      if (m_cnt + 1 >= eff_period(period_in, alt_mode)) begin
        m_cnt  = 0;
        m_lfsr = next_state(m_lfsr, alt_mode);
      end else begin
        m_cnt++;
      end
    end
  endtask

  // Drive inputs at the falling edge, then advance one clock and check.
  task automatic cyc(logic t, logic a, logic [7:0] p, string tag);
    @(negedge clk);
    tick_en = t; alt_mode = a; period_in = p;
    model_edge();
    @(negedge clk);
    check(noise_bit, m_lfsr[0], tag);
    tick_en = 1'b0;
    model_edge();
  endtask

  initial begin
    void'($urandom(32'd4711));
    m_lfsr = 17'd1;
    m_cnt = 0;
    repeat (3) @(negedge clk);
    check(noise_bit, 1'b1, "R1 reset seed");
    rst_n = 1'b1;
    model_edge();
    @(negedge clk);
    check(noise_bit, 1'b1, "R1 after release");

    // R7: period 0 steps on every tick; seed 1 -> bit16 set, bit0 0.
    cyc(1'b1, 1'b0, 8'd0, "R7 period zero");
    check(noise_bit, 1'b0, "R7 first step bit0");
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 8'd0, "R2 R4 std steps");
    // R8: no ticks, no change
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, 8'd3, "R8 idle hold");
    // R5: upper bits ignored in standard mode (0xE3 acts as 3)
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, 8'hE3, "R5 std masks upper");
    // R6: wide alternate period
    for (int i = 0; i < 600; i++) cyc(1'b1, 1'b1, 8'd200, "R6 alt wide period");
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b1, 8'd1, "R3 alt taps");
    // R9: build count high, then lower period
    for (int i = 0; i < 15; i++) cyc(1'b1, 1'b1, 8'd30, "R9 count up");
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 8'd2, "R9 lowered period");
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 8'd31, "R9 mode switch");

    // Constrained random phase
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] p;
      logic a;
      a = ($urandom % 8) == 0 ? ~alt_mode : alt_mode;
      case ($urandom % 4)
        0: p = 8'($urandom % 4);
        1: p = 8'($urandom % 32);
        2: p = 8'($urandom);
        default: p = 8'd250 + 8'($urandom % 6);
      endcase
      for (int k = 0; k < 1 + int'($urandom % 12); k++)
        cyc(($urandom % 3) != 0, a, p, "R2 R3 R8 R9 random");
    end

    // R1: reset mid-run returns to seed
    @(negedge clk);
    rst_n = 1'b0;
    model_edge();
    @(negedge clk);
    check(noise_bit, 1'b1, "R1 reseed");
    rst_n = 1'b1;
    model_edge();
    cyc(1'b1, 1'b0, 8'd1, "R10 restart");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule